// File: doc/BRIEF.md
# Windowed Watchdog Timer with Early-Warning Interrupt

This block watches over software by counting pulses of a slow tick, delivered as a one-cycle enable on the system clock. Software must refresh the counter before it reaches the configured overflow period. The only valid refresh is a write of the key value 0xAC to the refresh port. If the count runs out, the block issues a one-cycle reset request.

Refreshing is allowed only while the window is open. The window is the last half, the last three quarters, or all of the period. A write that arrives while the window is closed counts as a violation, and so does a write of any value other than the key. Either one raises the reset request at once.

An optional early-warning interrupt pulses shortly after three quarters of the period has elapsed. The interrupt leaves the count untouched, so software can use it to schedule a refresh. The period, the window and the interrupt enable are captured while reset is held. After that they stay fixed until the next reset.

Top module: `wwdt_core`

## Requirements
- R1: While reset is held and in the first cycle after its release, `irq` and `rst_req` are 0. The counter starts at zero, so with no writes the first overflow comes after exactly one full period of ticks.
- R2: The counter advances once per cycle in which `tick` is 1. With no refresh, the tick that completes P ticks since the last clear makes `rst_req` 1 for exactly one cycle, in the cycle after that tick. The counter then restarts from zero, so the next overflow comes after another P ticks.
- R3: `cfg_per_sel` value n gives a period P = 2^(6+n) ticks for n from 0 to 10. Any value above 10 gives P = 2^16.
- R4: With `cfg_win_sel` = 0 (half window), a write of 0xAC while the count is below P/2 causes a reset request. At or above P/2 the same write is accepted.
- R5: With `cfg_win_sel` = 1 (three-quarter window), a write of 0xAC while the count is below P/4 causes a reset request. At or above P/4 the same write is accepted.
- R6: With `cfg_win_sel` = 2 or 3 (full window), a write of 0xAC is accepted at any count, including zero.
- R7: A write of any value other than 0xAC causes a one-cycle reset request in the next cycle, whatever the count and the window.
- R8: An accepted write clears the counter without a reset request. The next overflow then comes P ticks after the write.
- R9: With `cfg_irq_en` = 1, `irq` pulses for one cycle after tick number 3P/4+1 since the last clear. Counting continues, so the overflow still comes at tick P.
- R10: With `cfg_irq_en` = 0, `irq` stays 0 for the whole period.
- R11: Changing `cfg_per_sel`, `cfg_win_sel` or `cfg_irq_en` after reset release has no effect until the next reset.
- R12: When a write and a tick arrive in the same cycle, the write decides the outcome and that tick is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is captured while low |
| tick | input | 1 | One-cycle enable from the slow timebase |
| cfg_per_sel | input | 4 | Period select, P = 2^(6+n), clamped at 2^16 |
| cfg_win_sel | input | 2 | Window: 0 half, 1 three-quarter, 2/3 full |
| cfg_irq_en | input | 1 | Enables the early-warning interrupt |
| wr_en | input | 1 | Refresh port write strobe |
| wr_data | input | 8 | Refresh port write data |
| irq | output | 1 | Early-warning interrupt pulse |
| rst_req | output | 1 | Reset request pulse |

## Verification
Every result is registered once. A reset request or interrupt caused by a tick or a write appears in the cycle right after the clock edge that takes that stimulus. The bench applies each tick or write at a falling edge and reads both outputs at the next falling edge. It logs the index of the tick on which each output first rises and compares that index with the number the requirement predicts (P, 3P/4+1, or the count at the time of a write). Window edges are tested from both sides, one tick below and exactly at the boundary.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;

    localparam int MIN_EXP = 6;
    localparam int MAX_EXP = 16;
    localparam int SEL_W   = 4;
    localparam int CNT_W   = MAX_EXP;
    localparam int EXP_W   = $clog2(MAX_EXP + 1);
    localparam logic [7:0] KEY = 8'hAC;

    typedef enum logic [1:0] {
        WIN_HALF  = 2'd0,
        WIN_3Q    = 2'd1,
        WIN_FULL  = 2'd2,
        WIN_FULL2 = 2'd3
    } win_mode_e;

    typedef struct packed {
        logic [SEL_W-1:0] per_sel;
        win_mode_e        win;
        logic             irq_en;
    } cfg_t;

endpackage

// File: rtl/wwdt_cfg.sv
module wwdt_cfg
    import wwdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] per_sel,
    input  logic [1:0]       win_sel,
    input  logic             irq_en,
    output cfg_t             cfg
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (!rst_n) begin
            cfg_d.per_sel = per_sel;
            cfg_d.win     = win_mode_e'(win_sel);
            cfg_d.irq_en  = irq_en;
        end
    end

    always_ff @(posedge clk) begin
        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

    // R11
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(cfg_q));

endmodule

// File: rtl/wwdt_cmp.sv
module wwdt_cmp
    import wwdt_pkg::*;
(
    input  cfg_t             cfg,
    input  logic [CNT_W-1:0] count,
    output logic             win_open,
    output logic             at_last,
    output logic             at_warn
);
    localparam int SEL_MAX = MAX_EXP - MIN_EXP;

    logic [EXP_W-1:0] exp_v;
    logic [CNT_W:0]   period;
    logic [CNT_W:0]   half_p;
    logic [CNT_W:0]   quart_p;
    logic [CNT_W:0]   limit;
    logic [CNT_W:0]   cnt_x;

    always_comb begin
        if (cfg.per_sel > SEL_W'(SEL_MAX))
            exp_v = EXP_W'(MAX_EXP);
        else
            exp_v = EXP_W'(MIN_EXP) + EXP_W'(cfg.per_sel);
        period  = (CNT_W+1)'(1) << exp_v;
        half_p  = period >> 1;
        quart_p = period >> 2;
        cnt_x   = {1'b0, count};
        unique case (cfg.win)
            WIN_HALF: limit = half_p;
            WIN_3Q:   limit = quart_p;
            default:  limit = '0;
        endcase
        win_open = cnt_x >= limit;
        at_last  = cnt_x == (period - 1'b1);
        at_warn  = cnt_x == (half_p + quart_p);
    end

endmodule

// File: rtl/wwdt_cnt.sv
module wwdt_cnt
    import wwdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (inc)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign count = cnt_q;

    // R8
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt_q == '0);

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr) |=> cnt_q == $past(cnt_q) + 1'b1);

endmodule

// File: rtl/wwdt_core.sv
module wwdt_core
    import wwdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [SEL_W-1:0] cfg_per_sel,
    input  logic [1:0]       cfg_win_sel,
    input  logic             cfg_irq_en,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    output logic             irq,
    output logic             rst_req
);
    typedef struct packed {
        logic irq;
        logic rreq;
    } out_t;

    cfg_t             cfg;
    logic [CNT_W-1:0] count;
    logic             win_open, at_last, at_warn;
    logic             key_ok, violation, overflow, cnt_clr, cnt_inc;
    out_t             out_d, out_q;

    wwdt_cfg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .per_sel (cfg_per_sel),
        .win_sel (cfg_win_sel),
        .irq_en  (cfg_irq_en),
        .cfg     (cfg)
    );

    wwdt_cmp u_cmp (
        .cfg      (cfg),
        .count    (count),
        .win_open (win_open),
        .at_last  (at_last),
        .at_warn  (at_warn)
    );

    wwdt_cnt u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .count (count)
    );

    always_comb begin
        key_ok    = wr_data == KEY;
        violation = wr_en && !(key_ok && win_open);
        overflow  = tick && !wr_en && at_last;
        cnt_clr   = wr_en || overflow;
        cnt_inc   = tick && !wr_en && !at_last;
        out_d.rreq = violation || overflow;
        out_d.irq  = tick && !wr_en && at_warn && cfg.irq_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            out_q <= '0;
        else
            out_q <= out_d;
    end

    assign irq     = out_q.irq;
    assign rst_req = out_q.rreq;

    // R7
    bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data != KEY) |=> rst_req);

    // R4
    closed_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !win_open) |=> rst_req);

    // R8
    good_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && key_ok && win_open) |=> (!rst_req && count == '0));

    // R2
    req_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> count == '0);

    // R9
    irq_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (count != '0 && !rst_req));

    // R10
    irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.irq_en |-> !irq);

endmodule

// File: tb/sim_wwdt_core.sv
module sim_wwdt_core;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [3:0] cfg_per_sel = '0;
    logic [1:0] cfg_win_sel = '0;
    logic       cfg_irq_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       irq, rst_req;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wwdt_core u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cfg_per_sel(cfg_per_sel), .cfg_win_sel(cfg_win_sel), .cfg_irq_en(cfg_irq_en),
        .wr_en(wr_en), .wr_data(wr_data), .irq(irq), .rst_req(rst_req)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [3:0] ps, input logic [1:0] ws, input logic ie);
        @(negedge clk);
        rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0;
        cfg_per_sel = ps; cfg_win_sel = ws; cfg_irq_en = ie;
        repeat (3) @(negedge clk);
        check(irq == 1'b0 && rst_req == 1'b0, "R1 outputs in reset", {irq, rst_req}, 0);
        rst_n = 1'b1;
    endtask

    // Applies n ticks; logs the tick index of the first rst_req and irq
    task automatic run_ticks(input int n, output int rr_first, output int rr_cnt,
                             output int irq_first, output int irq_cnt);
        rr_first = 0; rr_cnt = 0; irq_first = 0; irq_cnt = 0;
        for (int i = 1; i <= n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            if (rst_req) begin rr_cnt++; if (rr_first == 0) rr_first = i; end
            if (irq) begin irq_cnt++; if (irq_first == 0) irq_first = i; end
        end
        tick = 1'b0;
    endtask

    // One write; returns rst_req in the following cycle
    task automatic do_write(input logic [7:0] d, input logic with_tick, output logic rr);
        wr_en = 1'b1; wr_data = d; tick = with_tick;
        @(negedge clk);
        rr = rst_req;
        wr_en = 1'b0; tick = 1'b0;
    endtask

    task automatic t_reset_overflow();
        int rf, rc, inf, ic;
        do_reset(4'd0, 2'd2, 1'b0);
        check(irq == 1'b0 && rst_req == 1'b0, "R1 after release", {irq, rst_req}, 0);
        run_ticks(130, rf, rc, inf, ic);
        check(rf == 64, "R1 first overflow tick", rf, 64);
        check(rc == 2, "R2 pulses in 130 ticks", rc, 2);
        run_ticks(0, rf, rc, inf, ic);
    endtask

    task automatic t_period_sel();
        int rf, rc, inf, ic;
        do_reset(4'd1, 2'd2, 1'b0);
        run_ticks(130, rf, rc, inf, ic);
        check(rf == 128, "R3 sel1 period", rf, 128);
        do_reset(4'd11, 2'd2, 1'b0);
        run_ticks(65537, rf, rc, inf, ic);
        check(rf == 65536 && rc == 1, "R3 clamp to 2^16", rf, 65536);
    endtask

    task automatic t_window(input logic [1:0] ws, input int closed, input string req);
        int rf, rc, inf, ic;
        logic rr;
        do_reset(4'd0, ws, 1'b0);
        if (closed > 0) begin
            run_ticks(closed - 1, rf, rc, inf, ic);
            do_write(8'hAC, 1'b0, rr);
            check(rr == 1'b1, {req, " closed write"}, rr, 1);
            do_reset(4'd0, ws, 1'b0);
        end
        run_ticks(closed, rf, rc, inf, ic);
        do_write(8'hAC, 1'b0, rr);
        check(rr == 1'b0, {req, " open write at boundary"}, rr, 0);
        run_ticks(64, rf, rc, inf, ic);
        check(rf == 64, "R8 overflow after refresh", rf, 64);
    endtask

    task automatic t_bad_key();
        int rf, rc, inf, ic;
        logic rr;
        do_reset(4'd0, 2'd2, 1'b0);
        run_ticks(40, rf, rc, inf, ic);
        do_write(8'h55, 1'b0, rr);
        check(rr == 1'b1, "R7 wrong key", rr, 1);
        run_ticks(1, rf, rc, inf, ic);
        check(rc == 0, "R7 pulse is one cycle", rc, 0);
        run_ticks(63, rf, rc, inf, ic);
        check(rf == 63, "R2 restart after request", rf, 63);
    endtask

    task automatic t_irq(input logic en);
        int rf, rc, inf, ic;
        do_reset(4'd0, 2'd2, en);
        run_ticks(64, rf, rc, inf, ic);
        if (en) begin
            check(inf == 49 && ic == 1, "R9 irq tick", inf, 49);
            check(rf == 64, "R9 count continues", rf, 64);
        end else begin
            check(ic == 0, "R10 irq disabled", ic, 0);
        end
    endtask

    task automatic t_cfg_frozen();
        int rf, rc, inf, ic;
        logic rr;
        do_reset(4'd0, 2'd2, 1'b0);
        @(negedge clk);
        cfg_per_sel = 4'd3; cfg_win_sel = 2'd0; cfg_irq_en = 1'b1;
        do_write(8'hAC, 1'b0, rr);
        check(rr == 1'b0, "R11 window unchanged", rr, 0);
        run_ticks(64, rf, rc, inf, ic);
        check(rf == 64 && ic == 0, "R11 period and irq unchanged", rf, 64);
    endtask

    task automatic t_tick_and_write();
        int rf, rc, inf, ic;
        logic rr;
        do_reset(4'd0, 2'd2, 1'b0);
        run_ticks(63, rf, rc, inf, ic);
        do_write(8'hAC, 1'b1, rr);
        check(rr == 1'b0, "R12 write wins over tick", rr, 0);
        run_ticks(64, rf, rc, inf, ic);
        check(rf == 64, "R12 tick not counted", rf, 64);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset_overflow();
        t_period_sel();
        t_window(2'd0, 32, "R4");
        t_window(2'd1, 16, "R5");
        t_window(2'd2, 0, "R6");
        t_window(2'd3, 0, "R6");
        t_bad_key();
        t_irq(1'b1);
        t_irq(1'b0);
        t_cfg_frozen();
        t_tick_and_write();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule